// File: doc/BRIEF.md
# Edge Timestamp Capture Unit

This block stamps signal transitions with hardware precision. A free-running 32-bit counter advances on every cycle of a fast time-base clock. Several asynchronous event lines are watched for transitions. Each rising or falling transition becomes a record that holds the count of the cycle in which it was seen, the line number and the direction. Records wait in a small queue until a host controller fetches them.

The host reads records over a four-wire serial slave port in mode 0 (clock idles low, the host samples on the rising edge). The host can sleep between reads. An interrupt line stays high while any record is queued, and it also gives a one-cycle pulse each time the low 15 bits of the counter wrap. The host uses that pulse to extend the time base in software.

Simultaneous transitions are queued one per cycle, lowest line first. Each one keeps the stamp of the cycle in which it was detected. Transitions that cannot be stored set a sticky loss flag, and that flag travels with the next record read.

Top module: `evt_stamp`

## Requirements
- R1: The stamp in a record equals the counter value in the cycle in which the event input changed, plus two. The counter is 0 in the first cycle after reset release and increments by one on every clock.
- R2: Every transition on an event line produces exactly one record. Bits 3:1 hold the line number, and bit 0 is 1 for a rising transition and 0 for a falling one.
- R3: A frame is 37 bits, sent most significant bit first on the serial data output. Bit 36 is the loss flag and bits 35:4 are the stamp. The first bit is valid before the first rising serial clock edge, and the output advances after each falling edge.
- R4: A record leaves the queue only when chip-select rises after at least 37 rising serial clock edges. A shorter transfer leaves the head record and the loss flag in place.
- R5: Transitions on several lines in the same cycle are queued in ascending line order, and all of them carry the stamp of that cycle.
- R6: When the queue (8 records) is full, new transitions are discarded, and the records already stored are read out unchanged.
- R7: A discarded transition sets the loss flag. The flag appears as bit 36 of the next frame read to completion and is then clear, unless a new loss occurs.
- R8: A transition on a line whose previous transition has not yet been written into the queue is discarded and sets the loss flag.
- R9: irq is high in every cycle in which the queue holds at least one record.
- R10: irq pulses high for exactly one cycle whenever the counter is a nonzero multiple of 0x8000, independent of the queue.
- R11: After reset the queue is empty, the loss flag is clear, irq is low and the counter is 0.
- R12: A frame read while the queue is empty carries zeros in bits 35:0 and removes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Time-base clock; one tick of the stamp counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| evtIn | input | 8 | Asynchronous event lines, one per channel |
| spiSclk | input | 1 | Serial clock from the host, mode 0 |
| spiCsN | input | 1 | Active-low chip-select from the host |
| spiMiso | output | 1 | Serial record data to the host |
| irq | output | 1 | Queue-not-empty level, combined with the rollover pulse |

## Verification
The hardest situation to reach is a second transition on a line whose first transition is still waiting for its turn to be written. That window is open for only a few cycles. The bench switches all eight lines together, which makes line 7 wait seven cycles, and then reverses line 7 on the very next cycle, so the second transition lands inside that window. The full-queue loss needs nine closely spaced transitions with no read in between. It is combined with an aborted short read, which shows that the head record and the loss flag both survive an incomplete transfer.

// File: rtl/evt_stamp_pkg.sv
package evt_stamp_pkg;
  // Strobes issued by the control block to the datapath.
  typedef struct packed {
    logic push;       // write the granted channel's record into the queue
    logic pop;        // retire the head record
    logic loadFrame;  // copy loss flag and head record into the shifter
    logic shiftOut;   // advance the serial shifter by one bit
  } stampStrobes_t;
endpackage

// File: rtl/evt_stamp_ctrl.sv
module evt_stamp_ctrl
  import evt_stamp_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int FRAME_W = 37,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int BC_W = $clog2(FRAME_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] evtIn,
  input  logic              spiSclk,
  input  logic              spiCsN,
  input  logic              fifoFull,
  input  logic              fifoEmpty,
  output stampStrobes_t     strb,
  output logic [NUM_CH-1:0] capMask,
  output logic [CH_W-1:0]   grantCh,
  output logic              grantPol,
  output logic              ovfFlag
);
  // event synchronizers and edge detection
  logic [NUM_CH-1:0] evtS1, evtS2, evtS3, edgeVec;
  logic [NUM_CH-1:0] pend, pendPol, grantHot, accept;
  logic anyPend, collide, fullDrop, dropEvt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evtS1 <= '0;
      evtS2 <= '0;
      evtS3 <= '0;
    end else begin
      evtS1 <= evtIn;
      evtS2 <= evtS1;
      evtS3 <= evtS2;
    end
  end

  assign edgeVec = evtS2 ^ evtS3;

  // lowest pending channel wins the single write port
  always_comb begin
    anyPend = 1'b0;
    grantCh = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pend[i]) begin
        anyPend = 1'b1;
        grantCh = CH_W'(i);
      end
    end
  end

  assign grantHot = anyPend ? (NUM_CH'(1) << grantCh) : '0;
  assign grantPol = pendPol[grantCh];
  assign accept   = edgeVec & (~pend | grantHot);
  assign collide  = |(edgeVec & pend & ~grantHot);
  assign fullDrop = anyPend & fifoFull;
  assign dropEvt  = collide | fullDrop;
  assign capMask  = accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= '0;
      pendPol <= '0;
    end else begin
      pend    <= (pend & ~grantHot) | accept;
      pendPol <= (pendPol & ~accept) | (evtS2 & accept);
    end
  end

  // serial port sampled in the time-base domain
  logic sclkS1, sclkS2, sclkS3, csS1, csS2, csS3;
  logic sclkRise, sclkFall, csFall, csRise, frameDone, abortRd;
  logic [BC_W-1:0] bitCnt;
  logic frameValid, frameOvf, ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclkS1 <= 1'b0;
      sclkS2 <= 1'b0;
      sclkS3 <= 1'b0;
      csS1   <= 1'b1;
      csS2   <= 1'b1;
      csS3   <= 1'b1;
    end else begin
      sclkS1 <= spiSclk;
      sclkS2 <= sclkS1;
      sclkS3 <= sclkS2;
      csS1   <= spiCsN;
      csS2   <= csS1;
      csS3   <= csS2;
    end
  end

  assign sclkRise  = sclkS2 & ~sclkS3;
  assign sclkFall  = ~sclkS2 & sclkS3;
  assign csFall    = ~csS2 & csS3;
  assign csRise    = csS2 & ~csS3;
  assign frameDone = (bitCnt == BC_W'(FRAME_W));
  assign abortRd   = csRise & ~frameDone;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitCnt     <= '0;
      frameValid <= 1'b0;
      frameOvf   <= 1'b0;
      ovf        <= 1'b0;
    end else begin
      if (csFall) begin
        bitCnt     <= '0;
        frameValid <= ~fifoEmpty;
      end else if (sclkRise && !csS2 && !frameDone) begin
        bitCnt <= bitCnt + BC_W'(1);
      end
      if (csFall) begin
        frameOvf <= ovf;
        ovf      <= dropEvt;
      end else begin
        ovf <= ovf | dropEvt | (abortRd & frameOvf);
      end
    end
  end

  assign strb.push      = anyPend & ~fifoFull;
  assign strb.pop       = csRise & frameDone & frameValid;
  assign strb.loadFrame = csFall;
  assign strb.shiftOut  = sclkFall & ~csS2;
  assign ovfFlag        = ovf;
endmodule

// File: rtl/evt_stamp_dp.sv
module evt_stamp_dp
  import evt_stamp_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int CNT_W      = 32,
  parameter int FIFO_DEPTH = 8,
  parameter int ROLL_BIT   = 15,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int REC_W   = CNT_W + CH_W + 1,
  localparam int FRAME_W = REC_W + 1,
  localparam int AW      = $clog2(FIFO_DEPTH),
  localparam int PW      = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  stampStrobes_t     strb,
  input  logic [NUM_CH-1:0] capMask,
  input  logic [CH_W-1:0]   grantCh,
  input  logic              grantPol,
  input  logic              ovfFlag,
  output logic              fifoFull,
  output logic              fifoEmpty,
  output logic              rollTick,
  output logic              spiMiso
);
  logic [CNT_W-1:0] tsCnt;
  logic [CNT_W-1:0] chStamp [NUM_CH];
  logic [REC_W-1:0] fifoMem [FIFO_DEPTH];
  logic [PW-1:0]    wrPtr, rdPtr;
  logic [REC_W-1:0] headRec;
  logic [FRAME_W-1:0] shiftReg;

  // time base and rollover tick (high while low bits read zero after a wrap)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tsCnt    <= '0;
      rollTick <= 1'b0;
    end else begin
      tsCnt    <= tsCnt + CNT_W'(1);
      rollTick <= &tsCnt[ROLL_BIT-1:0];
    end
  end

  // per-channel stamp held until the record is written
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++) chStamp[c] <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++)
        if (capMask[c]) chStamp[c] <= tsCnt;
    end
  end

  assign fifoEmpty = (wrPtr == rdPtr);
  assign fifoFull  = (wrPtr[AW-1:0] == rdPtr[AW-1:0]) && (wrPtr[AW] != rdPtr[AW]);

  always_ff @(posedge clk) begin
    if (strb.push) fifoMem[wrPtr[AW-1:0]] <= {chStamp[grantCh], grantCh, grantPol};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.push) wrPtr <= wrPtr + PW'(1);
      if (strb.pop)  rdPtr <= rdPtr + PW'(1);
    end
  end

  assign headRec = fifoEmpty ? REC_W'(0) : fifoMem[rdPtr[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg <= '0;
    end else if (strb.loadFrame) begin
      shiftReg <= {ovfFlag, headRec};
    end else if (strb.shiftOut) begin
      shiftReg <= {shiftReg[FRAME_W-2:0], 1'b0};
    end
  end

  assign spiMiso = shiftReg[FRAME_W-1];
endmodule

// File: rtl/evt_stamp.sv
module evt_stamp
  import evt_stamp_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int CNT_W      = 32,
  parameter int FIFO_DEPTH = 8,
  parameter int ROLL_BIT   = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] evtIn,
  input  logic              spiSclk,
  input  logic              spiCsN,
  output logic              spiMiso,
  output logic              irq
);
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int FRAME_W = CNT_W + CH_W + 2;

  stampStrobes_t     strb;
  logic [NUM_CH-1:0] capMask;
  logic [CH_W-1:0]   grantCh;
  logic              grantPol, ovfFlag, fifoFull, fifoEmpty, rollTick;

  evt_stamp_ctrl #(.NUM_CH(NUM_CH), .FRAME_W(FRAME_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .evtIn(evtIn), .spiSclk(spiSclk), .spiCsN(spiCsN),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .strb(strb), .capMask(capMask),
    .grantCh(grantCh), .grantPol(grantPol), .ovfFlag(ovfFlag)
  );

  evt_stamp_dp #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .FIFO_DEPTH(FIFO_DEPTH),
                 .ROLL_BIT(ROLL_BIT)) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .capMask(capMask), .grantCh(grantCh),
    .grantPol(grantPol), .ovfFlag(ovfFlag), .fifoFull(fifoFull),
    .fifoEmpty(fifoEmpty), .rollTick(rollTick), .spiMiso(spiMiso)
  );

  assign irq = ~fifoEmpty | rollTick;
endmodule

// File: rtl/evt_stamp_checker.sv
module evt_stamp_checker
  import evt_stamp_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int ROLL_BIT   = 15,
  localparam int OW = $clog2(FIFO_DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input stampStrobes_t strb,
  input logic          ovfFlag,
  input logic          fifoFull,
  input logic          rollTick,
  input logic          irq
);
  logic [OW-1:0]     occ;
  logic [ROLL_BIT:0] tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ  <= '0;
      tick <= '0;
    end else begin
      occ  <= occ + OW'(strb.push) - OW'(strb.pop);
      tick <= {tick[ROLL_BIT] | (&tick[ROLL_BIT-1:0]), tick[ROLL_BIT-1:0] + ROLL_BIT'(1)};
    end
  end

  p_irq_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (occ != '0) |-> irq);

  p_no_push_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strb.push |-> (occ != OW'(FIFO_DEPTH)));

  p_full_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fifoFull == (occ == OW'(FIFO_DEPTH)));

  p_no_pop_empty_r12: assert property (@(posedge clk) disable iff (!rst_n)
    strb.pop |-> (occ != '0));

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovfFlag && !strb.loadFrame) |=> ovfFlag);

  p_roll_align_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rollTick == ((tick[ROLL_BIT-1:0] == '0) && (tick != '0)));
endmodule

bind evt_stamp evt_stamp_checker #(.FIFO_DEPTH(FIFO_DEPTH), .ROLL_BIT(ROLL_BIT)) chk_i (
  .clk(clk), .rst_n(rst_n), .strb(strb), .ovfFlag(ovfFlag), .fifoFull(fifoFull),
  .rollTick(rollTick), .irq(irq)
);

// File: tb/evt_stamp_tb.sv
module evt_stamp_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH  = 8;
  localparam int FRAME_W = 37;
  localparam int HALF    = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NUM_CH-1:0] evtIn = '0;
  logic sclk = 1'b0;
  logic csN = 1'b1;
  logic miso, irq;
  int checks = 0;
  int errors = 0;
  logic [31:0] tbCnt = '0;
  logic [FRAME_W-1:0] fr;
  logic [31:0] st, st2;
  logic [31:0] stq [9];

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) if (rst_n) tbCnt <= tbCnt + 1;

  evt_stamp #(.NUM_CH(NUM_CH), .CNT_W(32), .FIFO_DEPTH(8), .ROLL_BIT(15)) dut_i (
    .clk(clk), .rst_n(rst_n), .evtIn(evtIn), .spiSclk(sclk), .spiCsN(csN),
    .spiMiso(miso), .irq(irq)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [FRAME_W-1:0] mk(input logic ovf, input logic [31:0] s,
                                            input int ch, input logic pol);
    return {ovf, s, 3'(ch), pol};
  endfunction

  function automatic logic rollNow();
    return (tbCnt != 0) && (tbCnt[14:0] == 15'd0);
  endfunction

  task automatic spiRead(input int nbits, output logic [FRAME_W-1:0] f);
    f = '0;
    @(negedge clk) csN = 1'b0;
    repeat (8) @(negedge clk);
    for (int b = 0; b < nbits; b++) begin
      f = {f[FRAME_W-2:0], miso};
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    csN = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic drive(input logic [NUM_CH-1:0] v, output logic [31:0] s);
    @(negedge clk);
    evtIn = v;
    s = tbCnt + 2;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(64'(irq), 64'(0), "R11 irq low after reset");
    spiRead(FRAME_W, fr);
    chk(64'(fr), 64'(0), "R11 R12 empty read after reset");
    chk(64'(irq), 64'(rollNow()), "R12 empty read leaves irq low");

    // every channel, both directions
    for (int ch = 0; ch < NUM_CH; ch++) begin
      for (int p = 1; p >= 0; p--) begin
        drive(evtIn ^ (NUM_CH'(1) << ch), st);
        repeat (6) @(negedge clk);
        chk(64'(irq), 64'(1), "R9 irq with queued record");
        spiRead(FRAME_W, fr);
        chk(64'(fr), 64'(mk(1'b0, st, ch, p[0])), "R1 R2 R3 single record");
        chk(64'(irq), 64'(rollNow()), "R9 irq drops after last read");
      end
    end

    // all lines rise together
    drive('1, st);
    repeat (20) @(negedge clk);
    for (int ch = 0; ch < NUM_CH; ch++) begin
      spiRead(FRAME_W, fr);
      chk(64'(fr), 64'(mk(1'b0, st, ch, 1'b1)), "R5 ascending order same stamp");
    end

    // all fall, line 7 reverses while still waiting
    drive('0, st);
    drive(8'h80, st2);
    repeat (20) @(negedge clk);
    for (int ch = 0; ch < NUM_CH; ch++) begin
      spiRead(FRAME_W, fr);
      chk(64'(fr), 64'(mk(ch == 0, st, ch, 1'b0)), "R8 R7 collision drop and loss flag");
    end
    spiRead(FRAME_W, fr);
    chk(64'(fr), 64'(0), "R8 dropped edge left no record");
    drive('0, st);
    repeat (8) @(negedge clk);
    spiRead(FRAME_W, fr);
    chk(64'(fr), 64'(mk(1'b0, st, 7, 1'b0)), "R2 line 7 fall after collision");

    // overfill the queue on line 3
    for (int k = 0; k < 9; k++) begin
      drive(evtIn ^ 8'h08, stq[k]);
      repeat (3) @(negedge clk);
    end
    repeat (10) @(negedge clk);
    chk(64'(irq), 64'(1), "R9 irq with full queue");
    spiRead(10, fr);
    chk(64'(fr[9:0]), 64'(mk(1'b1, stq[0], 3, 1'b1) >> 27), "R4 R3 partial frame bits");
    for (int k = 0; k < 8; k++) begin
      spiRead(FRAME_W, fr);
      chk(64'(fr), 64'(mk(k == 0, stq[k], 3, (k % 2) == 0)), "R6 R7 R4 stored records after overflow");
    end
    spiRead(FRAME_W, fr);
    chk(64'(fr), 64'(0), "R6 ninth edge discarded");
    drive('0, st);
    repeat (8) @(negedge clk);
    spiRead(FRAME_W, fr);
    chk(64'(fr), 64'(mk(1'b0, st, 3, 1'b0)), "R7 loss flag cleared after report");

    // rollover pulses around the next multiples of 0x8000
    while (tbCnt < 32'd65540) begin
      @(negedge clk);
      if (tbCnt > 3 && (tbCnt[14:0] >= 15'h7FFE || tbCnt[14:0] <= 15'd1))
        chk(64'(irq), 64'(rollNow()), "R10 rollover pulse");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule